// File: doc/BRIEF.md
# Fixed-Latency Ring Spike Node

This block is one station on a one-way ring that carries neuron spike events. A spike from the local neuron is stamped with the value of the shared timeslot counter at the moment it is seen. It is then placed on the ring at the next frame boundary, which is a cycle where the counter is a multiple of `N_NODES`. Every packet travels the whole ring, one register per station, so each station sees every spike. The station that sent a packet takes it off when it comes back. A frame boundary falls exactly `N_NODES` cycles after insertion, so the freed lane is the one the sender uses next.

Packets from sources that the node watches are put into an eight-entry buffer, ordered by timestamp with the oldest first. The head entry is handed to the local neuron once the counter reaches its timestamp plus `FIXED_DELAY`. The delay from spike to delivery is therefore the same for every pair of nodes, whatever the hop distance. Timestamps are compared modulo 2^TS_W, so the counter may wrap.

Two state machines hold the control. The injector has `INJ_IDLE` and `INJ_HOLD`. A spike moves it from `INJ_IDLE` to `INJ_HOLD`, and an accepted insertion moves it back to `INJ_IDLE`. The overflow tracker has `OVF_CLEAR` and `OVF_SEEN`. A packet that arrives while the buffer is full moves it from `OVF_CLEAR` to `OVF_SEEN`, and it stays there until reset.

Top module: `ring_spike_node`

## Requirements
- R1: While reset is low and right after it, `dn_valid`, `deliver_valid` and `overflow` are 0.
- R2: A valid upstream packet whose source differs from `NODE_ID` appears unchanged on `dn_*` in the next cycle.
- R3: A valid upstream packet whose source equals `NODE_ID` is not passed downstream; `dn_valid` is 0 in the next cycle unless the node inserts its own packet there.
- R4: A spike seen in a cycle with counter value S is sent as {source `NODE_ID`, timestamp S}. It is inserted in the first later cycle whose counter value mod `N_NODES` is 0, and it is visible on `dn_*` one cycle after that.
- R5: Only one local spike waits at a time. A spike that arrives while one is waiting is dropped, and so is a spike in the insertion cycle itself.
- R6: If a forwarded packet arrives in an insertion cycle, the forwarded packet wins. The waiting spike is then sent at the next frame boundary.
- R7: Only packets whose source is set in `watch_mask` (bit index = source ID) and differs from `NODE_ID` are buffered. No other packet is ever delivered.
- R8: The head entry is delivered, with `deliver_valid` high and its source and timestamp on `deliver_src`/`deliver_ts` for one cycle, in the first cycle where (counter − timestamp − `FIXED_DELAY`) mod 2^TS_W has its top bit clear. At most one entry is delivered per cycle.
- R9: Entries are delivered in timestamp order, whatever order they arrived in. Entries with equal timestamps leave in arrival order, one per cycle.
- R10: Timestamp order is modulo 2^TS_W: a timestamp just below the wrap point counts as older than a small one.
- R11: Eight entries fit in the buffer. A packet that arrives while eight are held is dropped, and `overflow` goes to 1 and stays there until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_cnt | input | TS_W | Shared free-running timeslot counter |
| spike_in | input | 1 | Local neuron fired this cycle |
| watch_mask | input | N_NODES | Bit i set: buffer spikes from source i |
| up_valid | input | 1 | Upstream packet valid |
| up_src | input | ID_W | Upstream packet source ID |
| up_ts | input | TS_W | Upstream packet timestamp |
| dn_valid | output | 1 | Downstream packet valid |
| dn_src | output | ID_W | Downstream packet source ID |
| dn_ts | output | TS_W | Downstream packet timestamp |
| deliver_valid | output | 1 | Spike handed to local neuron |
| deliver_src | output | ID_W | Source of delivered spike |
| deliver_ts | output | TS_W | Timestamp of delivered spike |
| overflow | output | 1 | Sticky: a buffered packet was dropped |

## Verification
The forwarding path is tried with a table of packets that mixes foreign sources, the node's own ID and idle cycles, which separates passing on from removal. Injection is tried with a spike followed by extra spikes, which separates the single waiting slot from queuing. It is also tried with a foreign packet landing on the frame boundary, which shows whether the forwarded packet takes priority. Delivery is tried four ways: arrival order opposite to timestamp order, equal timestamps, a masked source mixed with the node's own packets, and timestamps on both sides of the counter wrap. These patterns separate true sorting, tie stability, filtering and modulo comparison. A burst of nine packets with one timestamp shows whether the capacity limit and the sticky flag hold.

// File: rtl/ring_spike_pkg.sv
package ring_spike_pkg;

    // Local spike injector: idle, or holding one stamped spike
    typedef enum logic [0:0] {
        INJ_IDLE = 1'b0,
        INJ_HOLD = 1'b1
    } inj_state_t;

    // Sorted-buffer loss tracker
    typedef enum logic [0:0] {
        OVF_CLEAR = 1'b0,
        OVF_SEEN  = 1'b1
    } ovf_state_t;

endpackage

// File: rtl/rsn_injector.sv
module rsn_injector
    import ring_spike_pkg::*;
#(
    parameter int N_NODES = 4,
    parameter int TS_W    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] slot_cnt,
    input  logic            spike_in,
    input  logic            ins_ack,
    output logic            ins_req,
    output logic [TS_W-1:0] ins_ts
);

    inj_state_t      state_q, state_d;
    logic [TS_W-1:0] held_ts_q, held_ts_d;
    logic [TS_W-1:0] phase;
    logic            frame_start;

    // Frame boundary: every lane passes its owner when counter mod N == 0
    assign phase       = slot_cnt % TS_W'(N_NODES);
    assign frame_start = (phase == '0);

    always_comb begin
        state_d   = state_q;
        held_ts_d = held_ts_q;
        unique case (state_q)
            INJ_IDLE: begin
                if (spike_in) begin
                    state_d   = INJ_HOLD;
                    held_ts_d = slot_cnt;
                end
            end
            INJ_HOLD: begin
                // further spikes are dropped while one is held
                if (ins_ack) begin
                    state_d = INJ_IDLE;
                end
            end
            default: state_d = INJ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= INJ_IDLE;
            held_ts_q <= '0;
        end else begin
            state_q   <= state_d;
            held_ts_q <= held_ts_d;
        end
    end

    always_comb begin
        ins_req = (state_q == INJ_HOLD) && frame_start;
        ins_ts  = held_ts_q;
    end

endmodule

// File: rtl/rsn_ring_stage.sv
module rsn_ring_stage #(
    parameter int ID_W    = 2,
    parameter int TS_W    = 8,
    parameter int NODE_ID = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            up_valid,
    input  logic [ID_W-1:0] up_src,
    input  logic [TS_W-1:0] up_ts,
    input  logic            ins_req,
    input  logic [TS_W-1:0] ins_ts,
    output logic            ins_ack,
    output logic            dn_valid,
    output logic [ID_W-1:0] dn_src,
    output logic [TS_W-1:0] dn_ts
);

    localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

    logic pass_on;

    // Own packets are consumed here; everything else travels on
    assign pass_on = up_valid && (up_src != MY_ID);
    assign ins_ack = ins_req && !pass_on;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_valid <= 1'b0;
            dn_src   <= '0;
            dn_ts    <= '0;
        end else if (pass_on) begin
            dn_valid <= 1'b1;
            dn_src   <= up_src;
            dn_ts    <= up_ts;
        end else if (ins_req) begin
            dn_valid <= 1'b1;
            dn_src   <= MY_ID;
            dn_ts    <= ins_ts;
        end else begin
            dn_valid <= 1'b0;
            dn_src   <= '0;
            dn_ts    <= '0;
        end
    end

endmodule

// File: rtl/rsn_sort_buf.sv
module rsn_sort_buf
    import ring_spike_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int ID_W        = 2,
    parameter int TS_W        = 8,
    parameter int FIXED_DELAY = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] slot_cnt,
    input  logic            push,
    input  logic [ID_W-1:0] push_src,
    input  logic [TS_W-1:0] push_ts,
    output logic            deliver_valid,
    output logic [ID_W-1:0] deliver_src,
    output logic [TS_W-1:0] deliver_ts,
    output logic            overflow
);

    localparam logic [TS_W-1:0] DLY = TS_W'(FIXED_DELAY);

    // registered entries, index 0 is the oldest
    logic            ent_v [DEPTH];
    logic [ID_W-1:0] ent_s [DEPTH];
    logic [TS_W-1:0] ent_t [DEPTH];

    // after optional pop of the head
    logic            pv [DEPTH];
    logic [ID_W-1:0] ps [DEPTH];
    logic [TS_W-1:0] pt [DEPTH];

    // after optional insertion
    logic            nv [DEPTH];
    logic [ID_W-1:0] ns [DEPTH];
    logic [TS_W-1:0] nt [DEPTH];

    logic            not_newer [DEPTH];
    logic [TS_W-1:0] age_gap   [DEPTH];

    logic [TS_W-1:0] due_gap;
    logic            due;
    logic            full;
    logic            accept;

    ovf_state_t ovf_q, ovf_d;

    // head is due once counter - ts - delay is non-negative (modulo)
    assign due_gap = slot_cnt - ent_t[0] - DLY;
    assign due     = ent_v[0] && !due_gap[TS_W-1];
    assign full    = ent_v[DEPTH-1];
    assign accept  = push && !full;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // pop stage
        if (i < DEPTH - 1) begin : g_shift
            assign pv[i] = due ? ent_v[i+1] : ent_v[i];
            assign ps[i] = due ? ent_s[i+1] : ent_s[i];
            assign pt[i] = due ? ent_t[i+1] : ent_t[i];
        end else begin : g_tail
            assign pv[i] = due ? 1'b0 : ent_v[i];
            assign ps[i] = ent_s[i];
            assign pt[i] = ent_t[i];
        end

        // entry i stays ahead of the newcomer if its ts <= newcomer ts
        assign age_gap[i]   = push_ts - pt[i];
        assign not_newer[i] = pv[i] && !age_gap[i][TS_W-1];

        // insertion stage
        if (i == 0) begin : g_first
            always_comb begin
                if (!accept || not_newer[0]) begin
                    nv[0] = pv[0];
                    ns[0] = ps[0];
                    nt[0] = pt[0];
                end else begin
                    nv[0] = 1'b1;
                    ns[0] = push_src;
                    nt[0] = push_ts;
                end
            end
        end else begin : g_rest
            always_comb begin
                if (!accept || not_newer[i]) begin
                    nv[i] = pv[i];
                    ns[i] = ps[i];
                    nt[i] = pt[i];
                end else if (not_newer[i-1]) begin
                    nv[i] = 1'b1;
                    ns[i] = push_src;
                    nt[i] = push_ts;
                end else begin
                    nv[i] = pv[i-1];
                    ns[i] = ps[i-1];
                    nt[i] = pt[i-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_v[i] <= 1'b0;
                ent_s[i] <= '0;
                ent_t[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_v[i] <= nv[i];
                ent_s[i] <= ns[i];
                ent_t[i] <= nt[i];
            end
        end
    end

    // overflow tracker
    always_comb begin
        ovf_d = ovf_q;
        unique case (ovf_q)
            OVF_CLEAR: if (push && full) ovf_d = OVF_SEEN;
            OVF_SEEN:  ovf_d = OVF_SEEN;
            default:   ovf_d = OVF_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= OVF_CLEAR;
        else        ovf_q <= ovf_d;
    end

    always_comb begin
        overflow      = (ovf_q == OVF_SEEN);
        deliver_valid = due;
        deliver_src   = ent_s[0];
        deliver_ts    = ent_t[0];
    end

endmodule

// File: rtl/ring_spike_node.sv
module ring_spike_node #(
    parameter int N_NODES     = 4,
    parameter int NODE_ID     = 0,
    parameter int TS_W        = 8,
    parameter int DEPTH       = 8,
    parameter int FIXED_DELAY = 12,
    parameter int ID_W        = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TS_W-1:0]    slot_cnt,
    input  logic               spike_in,
    input  logic [N_NODES-1:0] watch_mask,
    input  logic               up_valid,
    input  logic [ID_W-1:0]    up_src,
    input  logic [TS_W-1:0]    up_ts,
    output logic               dn_valid,
    output logic [ID_W-1:0]    dn_src,
    output logic [TS_W-1:0]    dn_ts,
    output logic               deliver_valid,
    output logic [ID_W-1:0]    deliver_src,
    output logic [TS_W-1:0]    deliver_ts,
    output logic               overflow
);

    // FIXED_DELAY is expected to cover up to N_NODES cycles of waiting for
    // a frame plus up to N_NODES hops of transit.

    localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

    logic            ins_req;
    logic            ins_ack;
    logic [TS_W-1:0] ins_ts;
    logic            src_known;
    logic            buf_push;

    assign src_known = (int'(up_src) < N_NODES);
    assign buf_push  = up_valid && (up_src != MY_ID) && src_known && watch_mask[up_src];

    rsn_injector #(
        .N_NODES (N_NODES),
        .TS_W    (TS_W)
    ) u_inj (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_cnt (slot_cnt),
        .spike_in (spike_in),
        .ins_ack  (ins_ack),
        .ins_req  (ins_req),
        .ins_ts   (ins_ts)
    );

    rsn_ring_stage #(
        .ID_W    (ID_W),
        .TS_W    (TS_W),
        .NODE_ID (NODE_ID)
    ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (up_valid),
        .up_src   (up_src),
        .up_ts    (up_ts),
        .ins_req  (ins_req),
        .ins_ts   (ins_ts),
        .ins_ack  (ins_ack),
        .dn_valid (dn_valid),
        .dn_src   (dn_src),
        .dn_ts    (dn_ts)
    );

    rsn_sort_buf #(
        .DEPTH       (DEPTH),
        .ID_W        (ID_W),
        .TS_W        (TS_W),
        .FIXED_DELAY (FIXED_DELAY)
    ) u_sort (
        .clk           (clk),
        .rst_n         (rst_n),
        .slot_cnt      (slot_cnt),
        .push          (buf_push),
        .push_src      (up_src),
        .push_ts       (up_ts),
        .deliver_valid (deliver_valid),
        .deliver_src   (deliver_src),
        .deliver_ts    (deliver_ts),
        .overflow      (overflow)
    );

endmodule

// File: rtl/ring_spike_node_chk.sv
module ring_spike_node_chk #(
    parameter int N_NODES     = 4,
    parameter int NODE_ID     = 0,
    parameter int TS_W        = 8,
    parameter int FIXED_DELAY = 12,
    parameter int ID_W        = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [TS_W-1:0] slot_cnt,
    input logic            up_valid,
    input logic [ID_W-1:0] up_src,
    input logic [TS_W-1:0] up_ts,
    input logic            dn_valid,
    input logic [ID_W-1:0] dn_src,
    input logic [TS_W-1:0] dn_ts,
    input logic            deliver_valid,
    input logic [ID_W-1:0] deliver_src,
    input logic [TS_W-1:0] deliver_ts,
    input logic            overflow
);

    localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

    logic            prev_frame;
    logic [TS_W-1:0] late_gap;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_frame <= 1'b0;
        else        prev_frame <= ((slot_cnt % TS_W'(N_NODES)) == '0);
    end

    assign late_gap = slot_cnt - deliver_ts - TS_W'(FIXED_DELAY);

    // R2: foreign packets move on unchanged one cycle later
    a_r2_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_src != MY_ID) |=>
        (dn_valid && dn_src == $past(up_src) && dn_ts == $past(up_ts)));

    // R4: own packet only appears after a frame-boundary cycle
    a_r4_own_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_src == MY_ID) |-> prev_frame);

    // R7: the node never delivers its own spikes
    a_r7_no_own_delivery: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_valid |-> (deliver_src != MY_ID));

    // R8: a spike is never delivered before ts + FIXED_DELAY
    a_r8_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_valid |-> !late_gap[TS_W-1]);

    // R11: overflow stays set
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

bind ring_spike_node ring_spike_node_chk #(
    .N_NODES     (N_NODES),
    .NODE_ID     (NODE_ID),
    .TS_W        (TS_W),
    .FIXED_DELAY (FIXED_DELAY),
    .ID_W        (ID_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .slot_cnt      (slot_cnt),
    .up_valid      (up_valid),
    .up_src        (up_src),
    .up_ts         (up_ts),
    .dn_valid      (dn_valid),
    .dn_src        (dn_src),
    .dn_ts         (dn_ts),
    .deliver_valid (deliver_valid),
    .deliver_src   (deliver_src),
    .deliver_ts    (deliver_ts),
    .overflow      (overflow)
);

// File: tb/sim_ring_spike_node.sv
module sim_ring_spike_node;

    localparam int NN  = 4;
    localparam int ME  = 1;
    localparam int TSW = 8;
    localparam int IDW = 2;
    localparam int DLY = 12;

    // {valid, src, ts, expect forwarded}
    localparam logic [11:0] FWD_VEC [6] = '{
        {1'b1, 2'd0, 8'h11, 1'b1},
        {1'b1, 2'd1, 8'h22, 1'b0},
        {1'b1, 2'd3, 8'hA5, 1'b1},
        {1'b0, 2'd2, 8'h33, 1'b0},
        {1'b1, 2'd2, 8'hFF, 1'b1},
        {1'b1, 2'd1, 8'h00, 1'b0}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [TSW-1:0] slot;
    logic           spike_in = 1'b0;
    logic [NN-1:0]  mask = '0;
    logic           up_valid = 1'b0;
    logic [IDW-1:0] up_src = '0;
    logic [TSW-1:0] up_ts = '0;
    logic           dn_valid;
    logic [IDW-1:0] dn_src;
    logic [TSW-1:0] dn_ts;
    logic           deliver_valid;
    logic [IDW-1:0] deliver_src;
    logic [TSW-1:0] deliver_ts;
    logic           overflow;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) slot <= '0;
        else        slot <= slot + 8'd1;
    end

    ring_spike_node #(
        .N_NODES (NN), .NODE_ID (ME), .TS_W (TSW), .DEPTH (8), .FIXED_DELAY (DLY)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .slot_cnt (slot), .spike_in (spike_in),
        .watch_mask (mask), .up_valid (up_valid), .up_src (up_src), .up_ts (up_ts),
        .dn_valid (dn_valid), .dn_src (dn_src), .dn_ts (dn_ts),
        .deliver_valid (deliver_valid), .deliver_src (deliver_src),
        .deliver_ts (deliver_ts), .overflow (overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d (slot %0d)", req, act, exp, slot);
        end
    endtask

    task automatic end_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic push_pkt(input int src, input int ts);
        up_valid = 1'b1;
        up_src   = IDW'(src);
        up_ts    = TSW'(ts);
        @(negedge clk);
        up_valid = 1'b0;
        up_src   = '0;
        up_ts    = '0;
    endtask

    task automatic wait_slot(input int s);
        while (int'(slot) != s) @(negedge clk);
    endtask

    task automatic wait_phase(input int p);
        while ((int'(slot) % NN) != p) @(negedge clk);
    endtask

    // expected delivery in the current cycle: v=0 means none
    task automatic exp_del(input string req, input int v, input int src, input int ts);
        chk(req, int'(deliver_valid), v);
        if (v != 0) begin
            chk(req, int'(deliver_src), src);
            chk(req, int'(deliver_ts), ts);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        end_run();
    end

    initial begin
        int s0;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 dn_valid in reset", int'(dn_valid), 0);
        chk("R1 deliver_valid in reset", int'(deliver_valid), 0);
        chk("R1 overflow in reset", int'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dn_valid after reset", int'(dn_valid), 0);
        chk("R1 overflow after reset", int'(overflow), 0);

        // R2 / R3: table of forward and removal vectors
        for (int i = 0; i < 6; i++) begin
            up_valid = FWD_VEC[i][11];
            up_src   = FWD_VEC[i][10:9];
            up_ts    = FWD_VEC[i][8:1];
            @(negedge clk);
            chk(FWD_VEC[i][0] ? "R2 forward valid" : "R3 removal valid",
                int'(dn_valid), int'(FWD_VEC[i][0]));
            if (FWD_VEC[i][0]) begin
                chk("R2 forward src", int'(dn_src), int'(FWD_VEC[i][10:9]));
                chk("R2 forward ts", int'(dn_ts), int'(FWD_VEC[i][8:1]));
            end
        end
        up_valid = 1'b0;
        @(negedge clk);

        // R4 / R5: stamping, frame-aligned insertion, extra spikes dropped
        wait_phase(2);
        s0 = int'(slot);
        spike_in = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            spike_in = (k <= 2);
            if (k == 3) begin
                chk("R4 own packet sent", int'(dn_valid), 1);
                chk("R4 own src", int'(dn_src), ME);
                chk("R4 stamp", int'(dn_ts), s0);
            end else begin
                chk("R5 no extra packet", int'(dn_valid), 0);
            end
        end
        spike_in = 1'b0;

        // R6: forwarded packet wins the insertion cycle
        wait_phase(2);
        s0 = int'(slot);
        spike_in = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            spike_in = 1'b0;
            if (k == 2) begin
                up_valid = 1'b1; up_src = 2'd3; up_ts = 8'h55;
            end else begin
                up_valid = 1'b0; up_src = '0; up_ts = '0;
            end
            if (k == 3) begin
                chk("R6 forward wins", int'(dn_valid), 1);
                chk("R6 forward src", int'(dn_src), 3);
                chk("R6 forward ts", int'(dn_ts), 8'h55);
            end else if (k == 7) begin
                chk("R6 deferred insert", int'(dn_valid), 1);
                chk("R6 deferred src", int'(dn_src), ME);
                chk("R6 deferred ts", int'(dn_ts), s0);
            end else begin
                chk("R6 idle ring", int'(dn_valid), 0);
            end
        end

        // R8 / R9: out-of-order arrival, ties, own packet ignored
        mask = 4'b1111;
        wait_slot(40);
        push_pkt(2, 40);
        push_pkt(3, 38);
        push_pkt(0, 38);
        push_pkt(ME, 35);
        for (int k = 0; k < 11; k++) begin
            case (int'(slot))
                50:      exp_del("R9 oldest first", 1, 3, 38);
                51:      exp_del("R9 tie in arrival order", 1, 0, 38);
                52:      exp_del("R8 release at ts+delay", 1, 2, 40);
                default: exp_del("R8 no release", 0, 0, 0);
            endcase
            @(negedge clk);
        end

        // R7: masked source filtered
        mask = 4'b1011;
        wait_slot(80);
        push_pkt(2, 80);
        push_pkt(0, 81);
        for (int k = 0; k < 14; k++) begin
            if (int'(slot) == 93) exp_del("R7 watched source", 1, 0, 81);
            else                  exp_del("R7 masked source dropped", 0, 0, 0);
            @(negedge clk);
        end

        // R10: wrap-around ordering
        mask = 4'b1111;
        wait_slot(3);
        push_pkt(2, 2);
        push_pkt(0, 254);
        for (int k = 0; k < 12; k++) begin
            case (int'(slot))
                10:      exp_del("R10 pre-wrap ts first", 1, 0, 254);
                14:      exp_del("R10 post-wrap ts second", 1, 2, 2);
                default: exp_del("R10 no release", 0, 0, 0);
            endcase
            @(negedge clk);
        end

        // R11: capacity and sticky overflow
        wait_slot(30);
        for (int j = 0; j < 8; j++) push_pkt((j % 2 == 0) ? 0 : 2, 30);
        chk("R11 eight entries fit", int'(overflow), 0);
        push_pkt(3, 30);
        chk("R11 overflow set", int'(overflow), 1);
        for (int k = 0; k < 12; k++) begin
            if (int'(slot) >= 42 && int'(slot) <= 49)
                exp_del("R11 held entries delivered", 1, ((int'(slot) - 42) % 2 == 0) ? 0 : 2, 30);
            else
                exp_del("R11 dropped entry absent", 0, 0, 0);
            @(negedge clk);
        end
        chk("R11 overflow sticky", int'(overflow), 1);

        // R1: reset clears overflow
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 overflow cleared by reset", int'(overflow), 0);
        chk("R1 deliver idle after reset", int'(deliver_valid), 0);

        end_run();
    end

endmodule